// File: doc/BRIEF.md
# Cache Line Preload Hint Engine

This block accepts advisory preload hints from software and turns the ones that qualify into single-line fills of a small direct-mapped data cache. Each hint carries an address, a kind flag (data or instruction) and a cacheable attribute. A global data-cache enable applies to every hint. A hint is retired without memory traffic when it is of instruction kind, when the cache is off, when the region is not cacheable, or when the line is already resident. Only a true data miss starts a fill.

The block owns the tag, valid and line storage. A fill reads one 32-byte line as four 64-bit beats over a simple read interface and installs it. The demand path reaches the storage only through a read-only lookup port, which returns a hit flag and the addressed 64-bit word. One fill may be outstanding at a time. A one-cycle status pulse classifies every hint as dropped, hit or filled.

Top module: `line_preload_unit`

## Requirements
- R1: An instruction-kind hint (`hint_is_instr`=1) completes as dropped (status code 0), issues no memory request and changes no resident line, even when that line is present.
- R2: While `dcache_en` is 0, every hint completes as dropped (code 0) and issues no memory request.
- R3: A hint with `hint_cacheable`=0 completes as dropped (code 0) and issues no memory request.
- R4: The line address is the hint address with bits [4:0] cleared. It is used both for the lookup and for `mem_req_addr`.
- R5: A qualifying hint to a resident line completes as hit (code 1) with no memory request.
- R6: A qualifying miss raises exactly one request. The four returned beats are stored as words 0..3 of the line, where the word is selected by address bits [4:3]. The status reports filled (code 2) in the cycle after the last beat.
- R7: The index being filled reads as a miss on the lookup port from the acceptance of the hint until the last beat. Its tag and valid bit are written only with the last beat.
- R8: `hint_ready` is 0 from the acceptance of a miss until its fill ends. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R9: A beat with `mem_rsp_err`=1 abandons the fill. The line stays invalid, the hint completes as dropped (code 0), no further beats are expected for that request, and no error is signalled.
- R10: A fill replaces any line that occupies the same index. Afterwards the old tag misses and the new tag hits.
- R11: `stat_valid` is high for exactly one cycle per hint. For a dropped or hit hint, that cycle is the one after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hint_valid | input | 1 | Hint offered |
| hint_ready | output | 1 | Hint accepted this cycle when high with valid |
| hint_addr | input | 32 | Byte address of the hint |
| hint_is_instr | input | 1 | 1 = instruction-kind hint, 0 = data hint |
| hint_cacheable | input | 1 | Region attribute of the hint address |
| dcache_en | input | 1 | Global data-cache enable |
| mem_req_valid | output | 1 | Line read request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Line-aligned read address |
| mem_rsp_valid | input | 1 | A read beat is present |
| mem_rsp_data | input | 64 | Beat data, ascending address order |
| mem_rsp_err | input | 1 | Beat carries a bus error |
| dmd_addr | input | 32 | Demand-side lookup address |
| dmd_hit | output | 1 | Lookup address is resident |
| dmd_data | output | 64 | Word of the line selected by dmd_addr[4:3] |
| stat_valid | output | 1 | One-cycle completion pulse |
| stat_code | output | 2 | 0 dropped, 1 hit, 2 filled |

## Verification
Every combination of kind, enable and cacheable is swept against both absent and resident lines. A design that let one of these gates through would start a fill or report a hit where a drop is due. Each of the eight indices is filled and probed word by word with request stalls of different lengths. That exposes a wrong alignment, beat ordering, or a request that moves before it is taken. Probes between beats catch a line that becomes valid too early. Errors injected on the first and on a middle beat must leave the index empty and return a drop rather than a fill. A following replacement must evict the old tag, or a stale hit would show.

// File: rtl/lpu_pkg.sv
// Shared types for the line preload unit: completion codes and fill states.
package lpu_pkg;
    typedef enum logic [1:0] {
        ST_DROP = 2'd0,
        ST_HIT  = 2'd1,
        ST_FILL = 2'd2
    } lpu_status_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_BEAT = 2'd2
    } lpu_fill_e;
endpackage

// File: rtl/lpu_tag_store.sv
// Direct-mapped tag, valid and line storage with two read ports (hint check
// and demand lookup) and three write actions: invalidate, beat write, commit.
// Assumes the caller invalidates an index before writing beats into it.
module lpu_tag_store #(
    parameter int LINE_W = 27,
    parameter int IDX_W  = 3,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_W-1:0]        lk_line,
    output logic                     lk_hit,
    input  logic [LINE_W-1:0]        dm_line,
    input  logic [$clog2(BEATS)-1:0] dm_word,
    output logic                     dm_hit,
    output logic [BEAT_W-1:0]        dm_data,
    input  logic                     inv_en,
    input  logic [IDX_W-1:0]         inv_idx,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [$clog2(BEATS)-1:0] wr_beat,
    input  logic [BEAT_W-1:0]        wr_data,
    input  logic                     cm_en,
    input  logic [IDX_W-1:0]         cm_idx,
    input  logic [LINE_W-IDX_W-1:0]  cm_tag
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = LINE_W - IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [BEAT_W-1:0] data_q [SETS][BEATS];

    // Valid bits: cleared by reset and invalidate, set only by commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (cm_en)  valid_q[cm_idx]  <= 1'b1;
        end
    end

    // Tag and line payload storage, no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (cm_en) tag_q[cm_idx] <= cm_tag;
        if (wr_en) data_q[wr_idx][wr_beat] <= wr_data;
    end

    // Hint-side and demand-side tag compare.
    always_comb begin
        lk_hit  = valid_q[lk_line[IDX_W-1:0]] &&
                  (tag_q[lk_line[IDX_W-1:0]] == lk_line[LINE_W-1:IDX_W]);
        dm_hit  = valid_q[dm_line[IDX_W-1:0]] &&
                  (tag_q[dm_line[IDX_W-1:0]] == dm_line[LINE_W-1:IDX_W]);
        dm_data = data_q[dm_line[IDX_W-1:0]][dm_word];
    end

    // R7: a partially written line is never valid
    assert_beat_into_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid_q[wr_idx]);
    assert_commit_over_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> !valid_q[cm_idx]);
endmodule

// File: rtl/lpu_hint_class.sv
// Classifies an offered hint as drop, hit or miss from its attributes and
// the tag compare result. Purely combinational; exactly one output is high.
module lpu_hint_class (
    input  logic is_instr,
    input  logic cache_on,
    input  logic cacheable,
    input  logic present,
    output logic drop,
    output logic hit,
    output logic miss
);
    // Attribute gates take priority over the tag compare.
    always_comb begin
        drop = is_instr || !cache_on || !cacheable;
        hit  = !drop && present;
        miss = !drop && !present;
    end
endmodule

// File: rtl/lpu_fill_ctrl.sv
// Runs one line fill: holds the request until taken, counts beats in
// ascending order, writes each good beat, commits the tag on the last beat
// and abandons on an error beat. Assumes no beats follow an error beat.
module lpu_fill_ctrl
    import lpu_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 5,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LINE_W-1:0]        start_line,
    output logic                     idle,
    output logic                     active,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [LINE_W+OFF_W-1:0]  mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [BEAT_W-1:0]        mem_rsp_data,
    input  logic                     mem_rsp_err,
    output logic                     wr_en,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [$clog2(BEATS)-1:0] wr_beat,
    output logic [BEAT_W-1:0]        wr_data,
    output logic                     cm_en,
    output logic [IDX_W-1:0]         cm_idx,
    output logic [LINE_W-IDX_W-1:0]  cm_tag,
    output logic                     done_err
);
    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    lpu_fill_e         state_q;
    logic [BW-1:0]     beat_q;
    logic [LINE_W-1:0] line_q;

    // Fill sequencing: idle -> request -> beats -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            beat_q  <= '0;
            line_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (start) begin
                    line_q  <= start_line;
                    state_q <= FS_REQ;
                end
                FS_REQ: if (mem_req_ready) begin
                    beat_q  <= '0;
                    state_q <= FS_BEAT;
                end
                FS_BEAT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || beat_q == LAST_BEAT) state_q <= FS_IDLE;
                    else beat_q <= beat_q + 1'b1;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Request, storage write and completion strobes.
    always_comb begin
        idle          = (state_q == FS_IDLE);
        active        = (state_q == FS_BEAT);
        mem_req_valid = (state_q == FS_REQ);
        mem_req_addr  = {line_q, {OFF_W{1'b0}}};
        wr_en         = active && mem_rsp_valid && !mem_rsp_err;
        wr_idx        = line_q[IDX_W-1:0];
        wr_beat       = beat_q;
        wr_data       = mem_rsp_data;
        cm_en         = wr_en && (beat_q == LAST_BEAT);
        cm_idx        = line_q[IDX_W-1:0];
        cm_tag        = line_q[LINE_W-1:IDX_W];
        done_err      = active && mem_rsp_valid && mem_rsp_err;
    end

    // R8: an untaken request stays put
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R6: at most one request per fill; none while beats are being collected
    assert_single_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: rtl/line_preload_unit.sv
// Top of the preload hint engine. Accepts hints, drops non-qualifying ones,
// retires hits, starts one fill per true miss and reports each hint on a
// one-cycle status pulse. Assumes write-back is not needed for victims.
module line_preload_unit
    import lpu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 64,
    parameter int SETS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hint_valid,
    output logic              hint_ready,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              hint_is_instr,
    input  logic              hint_cacheable,
    input  logic              dcache_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    input  logic [ADDR_W-1:0] dmd_addr,
    output logic              dmd_hit,
    output logic [BEAT_W-1:0] dmd_data,
    output logic              stat_valid,
    output logic [1:0]        stat_code
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int LINE_W  = ADDR_W - OFF_W;
    localparam int TAG_W   = LINE_W - IDX_W;
    localparam int BEATS   = LINE_BYTES * 8 / BEAT_W;
    localparam int BW      = $clog2(BEATS);
    localparam int BYTE_OW = $clog2(BEAT_W / 8);

    logic [LINE_W-1:0] hint_line;
    logic [LINE_W-1:0] dmd_line;
    logic [BW-1:0]     dmd_word;
    logic              lk_hit, c_drop, c_hit, c_miss, accept;
    logic              f_idle, f_active, done_err;
    logic              wr_en, cm_en;
    logic [IDX_W-1:0]  wr_idx, cm_idx;
    logic [BW-1:0]     wr_beat;
    logic [BEAT_W-1:0] wr_data;
    logic [TAG_W-1:0]  cm_tag;
    logic              unused_low_bits;

    // Line alignment of hint and demand addresses.
    always_comb begin
        hint_line       = hint_addr[ADDR_W-1:OFF_W];
        dmd_line        = dmd_addr[ADDR_W-1:OFF_W];
        dmd_word        = dmd_addr[OFF_W-1:BYTE_OW];
        unused_low_bits = ^{hint_addr[OFF_W-1:0], dmd_addr[BYTE_OW-1:0]};
        hint_ready      = f_idle;
        accept          = hint_valid && hint_ready;
    end

    lpu_tag_store #(
        .LINE_W(LINE_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W), .BEATS(BEATS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_line(hint_line), .lk_hit(lk_hit),
        .dm_line(dmd_line), .dm_word(dmd_word), .dm_hit(dmd_hit), .dm_data(dmd_data),
        .inv_en(accept && c_miss), .inv_idx(hint_line[IDX_W-1:0]),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_beat(wr_beat), .wr_data(wr_data),
        .cm_en(cm_en), .cm_idx(cm_idx), .cm_tag(cm_tag)
    );

    lpu_hint_class u_class (
        .is_instr(hint_is_instr), .cache_on(dcache_en), .cacheable(hint_cacheable),
        .present(lk_hit), .drop(c_drop), .hit(c_hit), .miss(c_miss)
    );

    lpu_fill_ctrl #(
        .LINE_W(LINE_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W), .BEATS(BEATS)
    ) u_fill (
        .clk(clk), .rst_n(rst_n),
        .start(accept && c_miss), .start_line(hint_line),
        .idle(f_idle), .active(f_active),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_beat(wr_beat), .wr_data(wr_data),
        .cm_en(cm_en), .cm_idx(cm_idx), .cm_tag(cm_tag), .done_err(done_err)
    );

    // Completion pulse: immediate for drop/hit, at fill end for misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_code  <= ST_DROP;
        end else begin
            stat_valid <= (accept && !c_miss) || cm_en || done_err;
            if (accept && c_hit)        stat_code <= ST_HIT;
            else if (cm_en)             stat_code <= ST_FILL;
            else if (accept || done_err) stat_code <= ST_DROP;
        end
    end

    // R1/R2/R3: dropped hints retire at once with no request
    assert_drop_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (hint_is_instr || !dcache_en || !hint_cacheable)
        |=> stat_valid && stat_code == ST_DROP && !mem_req_valid);
    // R5: resident qualifying hint reports hit with no request
    assert_hit_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !hint_is_instr && dcache_en && hint_cacheable && dmd_hit && dmd_addr == hint_addr
        |=> stat_valid && stat_code == ST_HIT && !mem_req_valid);
    // R4: request is line aligned
    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);
    // R8: no hint accepted while a fill runs
    assert_ready_low_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || f_active) |-> !hint_ready);
    // R6: filled status follows a good beat
    assert_fill_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code == ST_FILL |-> $past(mem_rsp_valid && !mem_rsp_err));
    // R9: error beat retires the hint as dropped
    assert_err_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_active && mem_rsp_valid && mem_rsp_err |=> stat_valid && stat_code == ST_DROP && hint_ready);
endmodule

// File: tb/line_preload_unit_test.sv
`timescale 1ns/1ps
module line_preload_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hint_valid = 1'b0, hint_is_instr = 1'b0, hint_cacheable = 1'b0, dcache_en = 1'b0;
    logic [31:0] hint_addr = '0, dmd_addr = '0;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        hint_ready, mem_req_valid, dmd_hit, stat_valid;
    logic [31:0] mem_req_addr;
    logic [63:0] dmd_data;
    logic [1:0]  stat_code;
    int checks = 0;
    int errors = 0;

    line_preload_unit uut (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_ready(hint_ready), .hint_addr(hint_addr),
        .hint_is_instr(hint_is_instr), .hint_cacheable(hint_cacheable), .dcache_en(dcache_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .dmd_addr(dmd_addr), .dmd_hit(dmd_hit), .dmd_data(dmd_data),
        .stat_valid(stat_valid), .stat_code(stat_code)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return (32'(tag) << 8) | (32'(idx) << 5) | 32'(off);
    endfunction

    function automatic logic [63:0] pat(input logic [31:0] la, input int k);
        return {la, 32'hC0DE_0000 | 32'(k)};
    endfunction

    task automatic probe(input logic [31:0] a);
        dmd_addr = a;
        #1;
    endtask

    // exp: 0 drop, 1 hit, 2 fill; err_beat < 0 means no error
    task automatic run_hint(input logic [31:0] a, input bit ins, input bit en, input bit cach,
                            input int exp, input int err_beat, input int delay, input string req);
        logic [31:0] la;
        la = {a[31:5], 5'b0};
        @(negedge clk);
        hint_addr = a; hint_is_instr = ins; dcache_en = en; hint_cacheable = cach; hint_valid = 1'b1;
        chk("R8", "ready before offer", hint_ready, 1);
        @(negedge clk);
        hint_valid = 1'b0;
        if (exp != 2) begin
            chk(req, "status pulse", stat_valid, 1);
            chk(req, "status code", stat_code, exp);
            chk(req, "no request", mem_req_valid, 0);
            @(negedge clk);
            chk("R11", "pulse one cycle", stat_valid, 0);
            chk(req, "still no request", mem_req_valid, 0);
        end else begin
            chk("R11", "no early status", stat_valid, 0);
            chk("R8", "ready low in fill", hint_ready, 0);
            chk("R6", "request raised", mem_req_valid, 1);
            chk("R4", "aligned address", mem_req_addr, la);
            probe(la);
            chk("R7", "victim index empty", dmd_hit, 0);
            for (int d = 0; d < delay; d++) begin
                @(negedge clk);
                chk("R8", "request held", mem_req_valid, 1);
                chk("R8", "address held", mem_req_addr, la);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk("R6", "request dropped once taken", mem_req_valid, 0);
            for (int k = 0; k < 4; k++) begin
                mem_rsp_valid = 1'b1; mem_rsp_data = pat(la, k); mem_rsp_err = (k == err_beat);
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
                if (k == err_beat) break;
                if (k < 3) begin
                    probe(la);
                    chk("R7", "partial line invalid", dmd_hit, 0);
                    chk("R8", "ready low mid fill", hint_ready, 0);
                    chk("R6", "no status mid fill", stat_valid, 0);
                    if (k % 2 == 1) @(negedge clk);
                end
            end
            chk(err_beat >= 0 ? "R9" : "R6", "fill status pulse", stat_valid, 1);
            chk(err_beat >= 0 ? "R9" : "R6", "fill status code", stat_code, err_beat >= 0 ? 0 : 2);
            chk("R8", "ready after fill", hint_ready, 1);
            for (int k = 0; k < 4; k++) begin
                probe(la + 32'(8 * k));
                if (err_beat >= 0) begin
                    chk("R9", "line left invalid", dmd_hit, 0);
                end else begin
                    chk("R7", "line valid after last beat", dmd_hit, 1);
                    chk("R6", "beat order", dmd_data, pat(la, k));
                end
            end
            @(negedge clk);
            chk("R11", "fill pulse one cycle", stat_valid, 0);
            chk("R6", "single request", mem_req_valid, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset ready", hint_ready, 1);
        chk("R11", "reset status", stat_valid, 0);
        chk("R6", "reset request", mem_req_valid, 0);
        for (int i = 0; i < 8; i++) begin
            probe(mk(5, i, 0));
            chk("R7", "reset empty", dmd_hit, 0);
        end

        // Fill every index, with varying offsets and request stalls, then hit it.
        for (int i = 0; i < 8; i++) begin
            run_hint(mk(5, i, (i * 7) % 32), 0, 1, 1, 2, -1, i % 3, "R6");
            run_hint(mk(5, i, 31 - i), 0, 1, 1, 1, -1, 0, "R5");
        end

        // Attribute sweep on an absent line and on a resident line.
        for (int c = 0; c < 8; c++) begin
            bit ins, en, cach;
            ins = c[2]; en = c[1]; cach = c[0];
            if (!(ins == 0 && en && cach)) begin
                run_hint(mk(9, 0, 4), ins, en, cach, 0, -1, 0, ins ? "R1" : (!en ? "R2" : "R3"));
                run_hint(mk(5, 1, 8), ins, en, cach, 0, -1, 0, ins ? "R1" : (!en ? "R2" : "R3"));
                probe(mk(5, 0, 0));
                chk("R1", "resident line untouched", dmd_hit, 1);
                probe(mk(5, 1, 16));
                chk("R1", "resident data untouched", dmd_data, pat(mk(5, 1, 0), 2));
            end
        end

        // Replacement at index 0 by a new tag.
        run_hint(mk(9, 0, 4), 0, 1, 1, 2, -1, 2, "R10");
        probe(mk(5, 0, 0));
        chk("R10", "old tag evicted", dmd_hit, 0);
        run_hint(mk(9, 0, 20), 0, 1, 1, 1, -1, 0, "R10");

        // Bus errors on a middle beat and on the first beat.
        run_hint(mk(12, 3, 9), 0, 1, 1, 2, 2, 1, "R9");
        probe(mk(5, 3, 0));
        chk("R9", "victim gone after error", dmd_hit, 0);
        run_hint(mk(12, 4, 0), 0, 1, 1, 2, 0, 0, "R9");
        run_hint(mk(12, 3, 1), 0, 1, 1, 2, -1, 0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule